// File: doc/BRIEF.md
# Unstable High-Byte Store Address and Data Unit

This block produces the bus cycles of the three undocumented indexed stores of an 8-bit microprocessor core. These stores write either Y, X or the AND of A and X. When the indexed address carries into the next page, the stored register also damages the high byte of the target address. The written value is damaged by the high byte as well. The operand fetch has already run outside the block. The block receives the base address, the index byte, the addressing form, the register selector and the current register values with a one-cycle `start` pulse. It then drives a dummy read and one write over a one-access-per-clock bus.

When carry occurs in the index addition, the target high byte becomes (base high + 1) AND the stored value. The low byte always keeps the wrapped sum. The data written is the stored value ANDed with (final high byte + 1). That mask is skipped when `rdy` is low during the write cycle. A low `rdy` in any other cycle of the sequence stalls the unit. The indirect-indexed form spends one extra cycle without a bus access before its dummy read. This gap stands for the pointer cycle that the surrounding core owns.

Top module: `unstable_store_agu`

## Requirements
- R1: After a synchronous reset, `busy`, `bus_rd` and `bus_wr` are low.
- R2: With `ind_mode`=0, the cycle after `start` is accepted is a read (`bus_rd`=1) at {base high byte, low byte of base low + index}, using the high byte before carry.
- R3: With `ind_mode`=1, the cycle after acceptance has `busy`=1 with no access. The dummy read of R2 follows it.
- R4: The write follows the dummy read directly. Without carry from the low-byte addition, the write address equals base + index.
- R5: With carry, the write address is {(base high + 1) AND r, wrapped low byte}, where r is the stored value. The increment wraps from 0xFF to 0x00.
- R6: With `rdy` high in the write cycle, `bus_wdata` equals r AND (write-address high byte + 1).
- R7: With `rdy` low in the write cycle, `bus_wdata` equals r unmasked. The write still completes in that one cycle.
- R8: A low `rdy` during the dummy-read cycle or the gap cycle holds the unit there. In the dummy-read case the read repeats at the same address.
- R9: `store_sel` encoding: 0 stores Y, 1 stores X, 2 and 3 store A AND X. The value is taken when `start` is accepted.
- R10: `start` is ignored while `busy` is high.
- R11: Each operation issues exactly one write. `bus_rd` and `bus_wr` are never high together. `busy` falls in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| base_addr | input | 16 | Base address before indexing |
| index | input | 8 | Index byte added to the base low byte |
| ind_mode | input | 1 | 0 absolute-indexed, 1 indirect-indexed |
| store_sel | input | 2 | Stored value select, see R9 |
| reg_a | input | 8 | Accumulator value |
| reg_x | input | 8 | X register value |
| reg_y | input | 8 | Y register value |
| rdy | input | 1 | Ready; stalls non-write cycles, selects the data mask in the write cycle |
| busy | output | 1 | Operation in progress |
| bus_addr | output | 16 | Access address |
| bus_rd | output | 1 | Read strobe (dummy read) |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data, valid while `bus_wr` is high |

## Verification
Some rules hold in every cycle, and the assertions check those. The two strobes never overlap, and a write lasts one cycle. A write directly follows a read with the same low address byte. A stalled read holds its address. With `rdy` high, the write data never has a bit set outside the high-byte mask. The start-to-first-access timing of both addressing forms is also checked every cycle. Only the bench scenarios can show the actual corrupted high byte and the exact data value. The bench sweeps bases on both sides of page boundaries, uses stored values 0x00 and 0xFF, and applies each register selection. The same goes for the raw data written when `rdy` drops in the write cycle, and for a `start` pulse during busy leaving the operation unchanged.

// File: rtl/ushs_pkg.sv
package ushs_pkg;
  // Sequencer position; the access driven in a cycle follows the state entered.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_DUMMY = 2'd2,
    ST_WRITE = 2'd3
  } ushs_state_e;

  // Stored-value select codes (3 aliases 2).
  localparam logic [1:0] SEL_Y  = 2'd0;
  localparam logic [1:0] SEL_X  = 2'd1;
  localparam logic [1:0] SEL_AX = 2'd2;
endpackage

// File: rtl/ushs_reg_pick.sv
module ushs_reg_pick #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] x_val,
  input  logic [DATA_W-1:0] y_val,
  output logic [DATA_W-1:0] picked
);
  import ushs_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_Y:   picked = y_val;
      SEL_X:   picked = x_val;
      default: picked = a_val & x_val;
    endcase
  end
endmodule

// File: rtl/ushs_addr_calc.sv
module ushs_addr_calc #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] stored,
  output logic [ADDR_W-1:0] dummy_addr,
  output logic [ADDR_W-1:0] write_addr,
  output logic              crossed
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W:0]   lo_sum;
  logic [DATA_W-1:0] base_hi;
  logic [DATA_W-1:0] hi_inc;
  logic [DATA_W-1:0] wr_hi;

  assign base_hi = base[ADDR_W-1:DATA_W];
  assign lo_sum  = {1'b0, base[DATA_W-1:0]} + {1'b0, idx};
  assign crossed = lo_sum[DATA_W];
  assign hi_inc  = base_hi + ONE;

  // Per-bit high-byte corruption: on carry each bit survives only where the
  // stored value has a one.
  for (genvar b = 0; b < DATA_W; b++) begin : g_hi_bit
    assign wr_hi[b] = crossed ? (hi_inc[b] & stored[b]) : base_hi[b];
  end

  assign dummy_addr = {base_hi, lo_sum[DATA_W-1:0]};
  assign write_addr = {wr_hi, lo_sum[DATA_W-1:0]};
endmodule

// File: rtl/ushs_data_mask.sv
module ushs_data_mask #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] masked
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] hi_plus;

  assign hi_plus = addr_hi + ONE;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask_bit
    assign masked[b] = stored[b] & hi_plus[b];
  end
endmodule

// File: rtl/ushs_seq.sv
module ushs_seq (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  ind_mode,
  input  logic                  rdy,
  output ushs_pkg::ushs_state_e state,
  output ushs_pkg::ushs_state_e nxt,
  output logic                  accept
);
  import ushs_pkg::*;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ind_mode ? ST_GAP : ST_DUMMY;
      ST_GAP:   if (rdy)   nxt = ST_DUMMY;
      ST_DUMMY: if (rdy)   nxt = ST_WRITE;
      ST_WRITE:            nxt = ST_IDLE;
      default:             nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R11: the write state lasts exactly one cycle, whatever rdy does
  assert_one_write_R11: assert property (@(posedge clk) disable iff (rst)
    state == ST_WRITE |=> state == ST_IDLE);

  // R8: a stalled gap cycle does not advance
  assert_gap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP && !rdy) |=> state == ST_GAP);
endmodule

// File: rtl/unstable_store_agu.sv
module unstable_store_agu #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DATA_W-1:0] index,
  input  logic              ind_mode,
  input  logic [1:0]        store_sel,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_x,
  input  logic [DATA_W-1:0] reg_y,
  input  logic              rdy,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata
);
  import ushs_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  ushs_state_e state, nxt;
  logic        accept;

  logic [DATA_W-1:0] live_reg;
  logic [ADDR_W-1:0] h_base;
  logic [DATA_W-1:0] h_idx;
  logic [DATA_W-1:0] h_reg;

  logic [ADDR_W-1:0] op_base;
  logic [DATA_W-1:0] op_idx;
  logic [DATA_W-1:0] op_reg;

  logic [ADDR_W-1:0] dummy_addr;
  logic [ADDR_W-1:0] write_addr;
  logic              crossed;
  logic [DATA_W-1:0] masked;

  logic [DATA_W-1:0] wd_masked_q;
  logic [DATA_W-1:0] wd_raw_q;

  ushs_seq seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ind_mode (ind_mode),
    .rdy      (rdy),
    .state    (state),
    .nxt      (nxt),
    .accept   (accept)
  );

  ushs_reg_pick #(.DATA_W(DATA_W)) pick_i (
    .sel    (store_sel),
    .a_val  (reg_a),
    .x_val  (reg_x),
    .y_val  (reg_y),
    .picked (live_reg)
  );

  // Operands: live inputs in the accepting cycle, held copies afterwards.
  assign op_base = (state == ST_IDLE) ? base_addr : h_base;
  assign op_idx  = (state == ST_IDLE) ? index     : h_idx;
  assign op_reg  = (state == ST_IDLE) ? live_reg  : h_reg;

  ushs_addr_calc #(.DATA_W(DATA_W)) calc_i (
    .base       (op_base),
    .idx        (op_idx),
    .stored     (op_reg),
    .dummy_addr (dummy_addr),
    .write_addr (write_addr),
    .crossed    (crossed)
  );

  ushs_data_mask #(.DATA_W(DATA_W)) mask_i (
    .stored  (op_reg),
    .addr_hi (write_addr[ADDR_W-1:DATA_W]),
    .masked  (masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_base <= '0;
      h_idx  <= '0;
      h_reg  <= '0;
    end else if (accept) begin
      h_base <= base_addr;
      h_idx  <= index;
      h_reg  <= live_reg;
    end
  end

  // Registered bus outputs, loaded for the state being entered.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      bus_rd      <= 1'b0;
      bus_wr      <= 1'b0;
      bus_addr    <= '0;
      wd_masked_q <= '0;
      wd_raw_q    <= '0;
    end else begin
      busy   <= (nxt != ST_IDLE);
      bus_rd <= (nxt == ST_DUMMY);
      bus_wr <= (nxt == ST_WRITE);
      unique case (nxt)
        ST_DUMMY: bus_addr <= dummy_addr;
        ST_WRITE: bus_addr <= write_addr;
        default:  bus_addr <= '0;
      endcase
      if (nxt == ST_WRITE) begin
        wd_masked_q <= masked;
        wd_raw_q    <= op_reg;
      end
    end
  end

  // The mask choice follows rdy inside the write cycle itself.
  assign bus_wdata = bus_wr ? (rdy ? wd_masked_q : wd_raw_q) : '0;

  // R11: never a read and a write in the same cycle
  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R8: a stalled dummy read repeats at the same address
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !rdy) |=> (bus_rd && $stable(bus_addr)));

  // R4: the write follows the dummy read and keeps its low byte
  assert_wr_after_rd_R4: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> ($past(bus_rd) && bus_addr[DATA_W-1:0] == $past(bus_addr[DATA_W-1:0])));

  // R6: with rdy high the data has no bit outside (high byte + 1)
  assert_data_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && rdy) |-> ((bus_wdata & ~(bus_addr[ADDR_W-1:DATA_W] + ONE)) == '0));

  // R2: absolute form reads in the cycle after acceptance
  assert_abs_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !ind_mode) |=> bus_rd);

  // R3: indirect form spends one busy cycle with no access first
  assert_ind_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && ind_mode) |=> (busy && !bus_rd && !bus_wr));
endmodule

// File: tb/unstable_store_agu_tb_top.sv
`timescale 1ns/1ps
module unstable_store_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0;
  logic [7:0]  index = '0;
  logic        ind_mode = 1'b0;
  logic [1:0]  store_sel = '0;
  logic [7:0]  reg_a = '0, reg_x = '0, reg_y = '0;
  logic        rdy = 1'b1;
  logic        busy, bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  unstable_store_agu dut_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .index(index),
    .ind_mode(ind_mode), .store_sel(store_sel), .reg_a(reg_a), .reg_x(reg_x),
    .reg_y(reg_y), .rdy(rdy), .busy(busy), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [1:0] s, input logic [7:0] a,
                                         input logic [7:0] x, input logic [7:0] y);
    if (s == 2'd0)      return y;
    else if (s == 2'd1) return x;
    else                return a & x;
  endfunction

  function automatic logic [15:0] exp_dummy(input logic [15:0] b, input logic [7:0] i);
    logic [7:0] lo;
    lo = b[7:0] + i;
    return {b[15:8], lo};
  endfunction

  function automatic logic [15:0] exp_write(input logic [15:0] b, input logic [7:0] i,
                                            input logic [7:0] r);
    logic [8:0] s;
    logic [7:0] hi;
    s = {1'b0, b[7:0]} + {1'b0, i};
    hi = s[8] ? ((b[15:8] + 8'd1) & r) : b[15:8];
    return {hi, s[7:0]};
  endfunction

  task automatic run_op(input logic [15:0] b, input logic [7:0] i, input logic ind,
                        input logic [1:0] s, input logic [7:0] a, input logic [7:0] x,
                        input logic [7:0] y, input int stalls, input logic wr_rdy,
                        input logic poke);
    logic [7:0]  r;
    logic [15:0] da, wa;
    logic [7:0]  wd;
    logic [8:0]  sum;
    r   = exp_reg(s, a, x, y);
    da  = exp_dummy(b, i);
    wa  = exp_write(b, i, r);
    sum = {1'b0, b[7:0]} + {1'b0, i};
    wd  = wr_rdy ? (r & (wa[15:8] + 8'd1)) : r;
    base_addr = b; index = i; ind_mode = ind; store_sel = s;
    reg_a = a; reg_x = x; reg_y = y; rdy = 1'b1; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (ind) begin
      check(busy && !bus_rd && !bus_wr, "R3 gap cycle", {29'd0, busy, bus_rd, bus_wr}, 32'h4);
      @(posedge clk); @(negedge clk);
    end
    check(bus_rd && !bus_wr, "R2 dummy read strobe", {30'd0, bus_rd, bus_wr}, 32'h2);
    check(bus_addr == da, "R2 dummy read address", bus_addr, da);
    if (poke) begin
      start = 1'b1; base_addr = ~b; index = ~i; store_sel = ~s;
      reg_a = ~a; reg_x = ~x; reg_y = ~y;
    end
    for (int k = 0; k < stalls; k++) begin
      rdy = 1'b0;
      @(posedge clk); @(negedge clk);
      check(bus_rd && !bus_wr && bus_addr == da, "R8 stalled read held", bus_addr, da);
    end
    rdy = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    rdy = wr_rdy;
    #1;
    check(bus_wr && !bus_rd, "R11 write strobe", {30'd0, bus_rd, bus_wr}, 32'h1);
    if (sum[8]) check(bus_addr == wa, "R5 crossed write address", bus_addr, wa);
    else        check(bus_addr == wa, "R4 uncrossed write address", bus_addr, wa);
    if (poke) check(bus_addr == wa, "R10 start while busy ignored", bus_addr, wa);
    if (wr_rdy) check(bus_wdata == wd, "R6 R9 masked data", bus_wdata, wd);
    else        check(bus_wdata == wd, "R7 R9 raw data", bus_wdata, wd);
    @(posedge clk); @(negedge clk);
    rdy = 1'b1;
    check(!busy && !bus_wr && !bus_rd, "R11 done after one write",
          {29'd0, busy, bus_rd, bus_wr}, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250129));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!busy && !bus_rd && !bus_wr, "R1 reset state", {29'd0, busy, bus_rd, bus_wr}, 32'h0);

    // Directed corners
    run_op(16'h12FF, 8'h01, 1'b0, 2'd0, 8'h00, 8'h00, 8'hFF, 0, 1'b1, 1'b0); // cross, Y=FF
    run_op(16'h12FF, 8'h01, 1'b0, 2'd1, 8'h00, 8'h00, 8'h00, 0, 1'b1, 1'b0); // cross, X=00
    run_op(16'h1200, 8'h00, 1'b0, 2'd1, 8'h00, 8'hFF, 8'h00, 0, 1'b1, 1'b0); // no cross
    run_op(16'hFFFF, 8'hFF, 1'b0, 2'd2, 8'hFF, 8'hFF, 8'h00, 0, 1'b1, 1'b0); // hi wraps
    run_op(16'h34F0, 8'h20, 1'b1, 2'd2, 8'hF3, 8'h3F, 8'h00, 0, 1'b0, 1'b0); // ind, raw
    run_op(16'h40FE, 8'h05, 1'b0, 2'd3, 8'hFF, 8'hFF, 8'h00, 2, 1'b1, 1'b1); // stall, poke
    run_op(16'h7F80, 8'h7F, 1'b1, 2'd0, 8'h00, 8'h00, 8'hFF, 1, 1'b0, 1'b0); // edge, no cross
    run_op(16'h7F80, 8'h80, 1'b0, 2'd0, 8'h00, 8'h00, 8'hFF, 0, 1'b0, 1'b0); // cross, raw

    // Random sweep near page boundaries
    for (int n = 0; n < 60; n++) begin
      logic [15:0] b;
      logic [7:0]  i;
      b = 16'($urandom);
      if (n % 2 == 0) b[7:0] = 8'hF0 | 8'($urandom % 16);
      i = 8'($urandom);
      run_op(b, i, 1'($urandom), 2'($urandom), 8'($urandom),
             (n % 7 == 0) ? 8'hFF : 8'($urandom), (n % 5 == 0) ? 8'h00 : 8'($urandom),
             int'($urandom % 3), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule